// File: doc/BRIEF.md
# Charge Pump Gain and Speed-Up Controller

This block turns a two-bit gain setting and a handful of control inputs into digital current-scaling codes for three charge pumps in a fractional-N synthesizer: a main proportional pump, a main integral pump and an auxiliary pump. Each code is an integer count of half-units of the pump bias current. This encoding lets 0.5x and 1.5x settings be represented exactly.

The two main pumps enter a high-current speed-up state to shorten large frequency steps. The integral pump conducts only during speed-up. Normally, speed-up lasts for the serial-bus strobe pulse during which a main-divider word is taken in. Two test inputs override this: one holds speed-up on, and the other keeps it off and wins over the first. The upper gain bit switches the integral pump off entirely. The auxiliary pump depends only on the lower gain bit.

Top module: `cpump_gain_ctrl`

## Requirements
- R1: While rstN is low, auxCode, propCode and intCode are all 0.
- R2: auxCode is in half-units and depends only on gainSel[0]: 3 (1.5x) when gainSel[0]=0, and 1 (0.5x) when gainSel[0]=1.
- R3: Outside speed-up, propCode is 6 (3x) when gainSel[0]=0 and 2 (1x) when gainSel[0]=1, and intCode is 0.
- R4: During speed-up with gainSel[1]=0, propCode is 30 (15x) and intCode is 72 (36x) when gainSel[0]=0, and 10 and 24 when gainSel[0]=1.
- R5: When gainSel[1]=1, intCode is 0 in every state. propCode follows gainSel[0] as in R3 and R4.
- R6: A speed-up window opens in a cycle where mainWordLoad and strobe are both high. It lasts while strobe stays high and ends in the first cycle strobe is low. A mainWordLoad while strobe is low is ignored, and a strobe pulse with no load in it gives no speed-up.
- R7: While forceSpeedUp=1 and noSpeedUp=0, the main pumps are in speed-up regardless of strobe.
- R8: While noSpeedUp=1, speed-up never occurs, even with forceSpeedUp=1 or a load pulse.
- R9: auxCode never changes because of speed-up.
- R10: All three codes are registered. Input values sampled at a rising clock edge show on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| gainSel | input | 2 | Gain field; bit 1 turns off the integral pump, bit 0 selects low gain |
| mainWordLoad | input | 1 | One-cycle pulse when a main-divider word is taken in |
| strobe | input | 1 | Serial-bus strobe level |
| forceSpeedUp | input | 1 | Test input holding speed-up on |
| noSpeedUp | input | 1 | Test input keeping speed-up off; overrides forceSpeedUp |
| auxCode | output | CODE_W | Auxiliary pump multiplier in half-units |
| propCode | output | CODE_W | Proportional pump multiplier in half-units |
| intCode | output | CODE_W | Integral pump multiplier in half-units |

## Verification
Every code is due one rising edge after the inputs that set it are sampled. This includes a strobe fall, which ends speed-up in the very next output update. The driver changes inputs on the falling edge and queues the codes expected after the next rising edge. The monitor compares them two nanoseconds after that rising edge, so each check lands on exactly one register stage. The bench keeps its own model of the open speed-up window, so strobe pulses with and without a load are scored independently of the design.

// File: rtl/cpump_gain_pkg.sv
package cpump_gain_pkg;
  // multipliers in half-units per unit of the scale factor
  localparam int unsigned AUX_K   = 1;
  localparam int unsigned PROP_K  = 2;
  localparam int unsigned SU_K    = 10;
  localparam int unsigned INT_K   = 24;
  localparam int unsigned HI_SCALE = 3;
  localparam int unsigned LO_SCALE = 1;

  typedef struct packed {
    logic speedUp;
    logic intEnable;
    logic hiGain;
  } pumpCtrl_t;
endpackage

// File: rtl/cpump_speed_ctrl.sv
module cpump_speed_ctrl
  import cpump_gain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] gainSel,
  input  logic       mainWordLoad,
  input  logic       strobe,
  input  logic       forceSpeedUp,
  input  logic       noSpeedUp,
  output pumpCtrl_t  ctrl
);
  logic windowOpen;
  logic strobeReq;
  logic speedReq;

  // window stays open from a load within a strobe pulse until strobe drops
  always_ff @(posedge clk) begin
    if (!rstN)                 windowOpen <= 1'b0;
    else if (!strobe)          windowOpen <= 1'b0;
    else if (mainWordLoad)     windowOpen <= 1'b1;
  end

  always_comb begin
    strobeReq = strobe && (windowOpen || mainWordLoad);
    if (noSpeedUp)         speedReq = 1'b0;
    else if (forceSpeedUp) speedReq = 1'b1;
    else                   speedReq = strobeReq;
    ctrl.speedUp   = speedReq;
    ctrl.intEnable = !gainSel[1];
    ctrl.hiGain    = !gainSel[0];
  end
endmodule

// File: rtl/cpump_gain_dp.sv
module cpump_gain_dp
  import cpump_gain_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pumpCtrl_t         ctrl,
  output logic [CODE_W-1:0] auxCode,
  output logic [CODE_W-1:0] propCode,
  output logic [CODE_W-1:0] intCode
);
  int unsigned scaleI;
  logic [CODE_W-1:0] auxNxt;
  logic [CODE_W-1:0] propNxt;
  logic [CODE_W-1:0] intNxt;

  always_comb begin
    scaleI  = ctrl.hiGain ? HI_SCALE : LO_SCALE;
    auxNxt  = CODE_W'(AUX_K * scaleI);
    propNxt = CODE_W'((ctrl.speedUp ? SU_K : PROP_K) * scaleI);
    intNxt  = (ctrl.speedUp && ctrl.intEnable) ? CODE_W'(INT_K * scaleI) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxCode  <= '0;
      propCode <= '0;
      intCode  <= '0;
    end else begin
      auxCode  <= auxNxt;
      propCode <= propNxt;
      intCode  <= intNxt;
    end
  end
endmodule

// File: rtl/cpump_gain_ctrl.sv
module cpump_gain_ctrl
  import cpump_gain_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        gainSel,
  input  logic              mainWordLoad,
  input  logic              strobe,
  input  logic              forceSpeedUp,
  input  logic              noSpeedUp,
  output logic [CODE_W-1:0] auxCode,
  output logic [CODE_W-1:0] propCode,
  output logic [CODE_W-1:0] intCode
);
  pumpCtrl_t ctrl;

  cpump_speed_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .gainSel(gainSel), .mainWordLoad(mainWordLoad),
    .strobe(strobe), .forceSpeedUp(forceSpeedUp), .noSpeedUp(noSpeedUp),
    .ctrl(ctrl)
  );

  cpump_gain_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .auxCode(auxCode), .propCode(propCode), .intCode(intCode)
  );
endmodule

// File: rtl/cpump_gain_chk.sv
module cpump_gain_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        gainSel,
  input logic              mainWordLoad,
  input logic              strobe,
  input logic              forceSpeedUp,
  input logic              noSpeedUp,
  input logic [CODE_W-1:0] auxCode,
  input logic [CODE_W-1:0] propCode,
  input logic [CODE_W-1:0] intCode
);
  // R8
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    noSpeedUp |=> (propCode <= CODE_W'(6)) && (intCode == '0));

  // R7
  force_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceSpeedUp && !noSpeedUp) |=> (propCode == CODE_W'(30) || propCode == CODE_W'(10)));

  // R5
  int_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainSel[1] |=> intCode == '0);

  // R2
  aux_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gainSel[0] |=> auxCode == CODE_W'(3));

  // R9
  aux_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainSel[0] |=> auxCode == CODE_W'(1));

  // R6
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe && !forceSpeedUp) |=> propCode <= CODE_W'(6));

  // R4
  int_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gainSel[1] && !noSpeedUp && forceSpeedUp) |=> intCode != '0);
endmodule

bind cpump_gain_ctrl cpump_gain_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .gainSel(gainSel), .mainWordLoad(mainWordLoad),
  .strobe(strobe), .forceSpeedUp(forceSpeedUp), .noSpeedUp(noSpeedUp),
  .auxCode(auxCode), .propCode(propCode), .intCode(intCode)
);

// File: tb/cpump_gain_ctrl_tb.sv
module cpump_gain_ctrl_tb;
  localparam int CODE_W = 7;

  typedef struct {
    int    aux;
    int    prop;
    int    intc;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] gainSel = 2'b00;
  logic mainWordLoad = 1'b0;
  logic strobe = 1'b0;
  logic forceSpeedUp = 1'b0;
  logic noSpeedUp = 1'b0;
  logic [CODE_W-1:0] auxCode, propCode, intCode;

  int checks = 0;
  int errors = 0;
  bit windowM = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  cpump_gain_ctrl #(.CODE_W(CODE_W)) u_dut (
    .clk(clk), .rstN(rstN), .gainSel(gainSel), .mainWordLoad(mainWordLoad),
    .strobe(strobe), .forceSpeedUp(forceSpeedUp), .noSpeedUp(noSpeedUp),
    .auxCode(auxCode), .propCode(propCode), .intCode(intCode)
  );

  // drive on falling edge, queue the codes due after the next rising edge
  task automatic step(input logic [1:0] g, input logic ld, input logic stb,
                      input logic frc, input logic dis, input string tag);
    expItem_t e;
    bit su;
    int sc;
    @(negedge clk);
    gainSel = g; mainWordLoad = ld; strobe = stb;
    forceSpeedUp = frc; noSpeedUp = dis;
    su = dis ? 1'b0 : (frc ? 1'b1 : (stb && (windowM || ld)));
    windowM = !stb ? 1'b0 : (ld ? 1'b1 : windowM);
    sc = g[0] ? 1 : 3;
    e.aux  = sc;
    e.prop = su ? 10 * sc : 2 * sc;
    e.intc = (su && !g[1]) ? 24 * sc : 0;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (int'(auxCode) != e.aux || int'(propCode) != e.prop || int'(intCode) != e.intc) begin
        errors++;
        $display("FAIL %s: got aux=%0d prop=%0d int=%0d, expected aux=%0d prop=%0d int=%0d",
                 e.tag, auxCode, propCode, intCode, e.aux, e.prop, e.intc);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (auxCode != '0 || propCode != '0 || intCode != '0) begin
      errors++;
      $display("FAIL R1 reset: got aux=%0d prop=%0d int=%0d, expected 0 0 0",
               auxCode, propCode, intCode);
    end
    @(negedge clk);
    rstN = 1'b1;

    step(2'b00, 0, 0, 0, 0, "R2 R3 R10 idle high gain");
    step(2'b01, 0, 0, 0, 0, "R2 R3 idle low gain");
    step(2'b00, 1, 0, 0, 0, "R6 load with strobe low ignored");
    step(2'b00, 0, 1, 0, 0, "R6 strobe without load");
    step(2'b00, 0, 0, 0, 0, "R6 strobe drop");
    step(2'b00, 1, 1, 0, 0, "R4 R6 load opens window");
    step(2'b00, 0, 1, 0, 0, "R6 R9 window held by strobe");
    step(2'b01, 0, 1, 0, 0, "R4 R9 low gain in window");
    step(2'b01, 0, 0, 0, 0, "R6 strobe low ends window");
    step(2'b01, 0, 1, 0, 0, "R6 no reopen without load");
    step(2'b10, 1, 1, 0, 0, "R5 integral off high gain");
    step(2'b11, 0, 1, 0, 0, "R5 integral off low gain");
    step(2'b11, 0, 0, 0, 0, "R3 R5 idle gain 11");
    step(2'b00, 0, 0, 1, 0, "R7 force with strobe low");
    step(2'b01, 0, 0, 1, 0, "R7 force low gain");
    step(2'b00, 0, 0, 1, 1, "R8 disable beats force");
    step(2'b00, 1, 1, 0, 1, "R8 disable blocks load window");
    step(2'b00, 0, 1, 0, 0, "R6 R8 window open under disable");
    step(2'b00, 0, 0, 0, 0, "R6 final idle");

    wait (expQ.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule